// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and memory. It holds stores so that the processor can continue at once instead of waiting for memory to take each write. Each entry covers one block-aligned address. It holds a multi-word data block and one valid bit per word. An incoming store is looked up against every held entry. If its block is already held in an entry that is not currently being offered to memory, the store's word is written into that entry. Otherwise the store takes the next free entry. Stores to consecutive words therefore collapse into one masked multi-word write.

Entries drain to memory oldest first over a valid/ready handshake. Memory receives the block address, the full data block and a word mask. Loads do not wait for this draining and may reach memory ahead of older buffered stores. A load probe returns forwarded data in the same cycle when the buffer holds the requested word. When more than one entry holds that word, the newest entry supplies the data.

Top module: `merge_write_buffer`

## Requirements
- R1: After reset the buffer is empty: `mem_valid` is 0, `st_ready` is 1 and `ld_hit` is 0.
- R2: `st_addr` is a word address whose low log2(WORDS) bits select the word and whose upper bits form the block address. A store whose block matches a held entry that is not being offered to memory is merged into that entry: that word's data is replaced, its mask bit is set, and no new entry is used. Merging is allowed even when the buffer is full.
- R3: A store that cannot merge takes a new entry as the youngest. That entry's mask has only the store's word bit set, and all of its other data words are zero.
- R4: When the buffer is full and the store cannot merge, `st_ready` is 0 and the store leaves the buffer unchanged.
- R5: `mem_valid` is 1 exactly when the buffer holds at least one entry. `mem_blk_addr`, `mem_data` and `mem_mask` then describe the oldest entry: mask bit w marks word w, and word w occupies bits [w*DATA_W +: DATA_W].
- R6: The entry offered to memory accepts no merge. A store to its block takes a new entry, and the offered address, data and mask stay stable while `mem_ready` is 0.
- R7: Each cycle with `mem_valid` and `mem_ready` both 1 removes the oldest entry. Entries reach memory in the order in which they were allocated.
- R8: With `ld_valid` set, `ld_hit` is 1 exactly when some entry holds the load's block with that word's mask bit set. `ld_data` is then the word from the newest such entry. The lookup sees the entries as they stood at the start of the cycle.
- R9: A load probe, whether it hits or misses, does not change the contents of the buffer.
- R10: A store may allocate in the same cycle that the oldest entry drains, and both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted this cycle when high |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data word |
| ld_valid | input | 1 | Load probe request |
| ld_addr | input | ADDR_W | Load word address |
| ld_hit | output | 1 | Requested word is held in the buffer |
| ld_data | output | DATA_W | Forwarded word, valid with ld_hit |
| mem_valid | output | 1 | Oldest entry offered to memory |
| mem_ready | input | 1 | Memory takes the offered entry |
| mem_blk_addr | output | ADDR_W-log2(WORDS) | Block address of offered entry |
| mem_data | output | WORDS*DATA_W | Data block of offered entry |
| mem_mask | output | WORDS | Valid-word mask of offered entry |

## Verification
Several store patterns are applied. Consecutive words in one block while memory is stalled show that merging happens and that the entry offered to memory stays locked. A burst to distinct blocks fills the buffer, and a further new block then tells an allocation stall apart from a store that can still merge into a younger entry. The loads in the bench tell the following cases apart: newest-copy forwarding over an older locked copy, a miss on a held block whose word is not valid, and a miss on a block that is not held. The bench drains the buffer and overlaps stores with draining, which checks the oldest-first order and simultaneous allocate-and-drain. A long random mix over a few blocks is then compared cycle by cycle against a queue model.

// File: rtl/mwb_pkg.sv
`timescale 1ns/1ps
package mwb_pkg;
  // where a forwarded load word comes from
  typedef enum logic [1:0] {
    FWD_NONE  = 2'd0,
    FWD_HEAD  = 2'd1,
    FWD_YOUNG = 2'd2
  } fwd_src_e;
endpackage

// File: rtl/mwb_cam.sv
`timescale 1ns/1ps
module mwb_cam #(
  parameter int DEPTH = 4,
  parameter int BLK_W = 10
) (
  input  logic [DEPTH-1:0]       vld_i,
  input  logic [DEPTH-1:0]       excl_i,
  input  logic [DEPTH*BLK_W-1:0] blk_i,
  input  logic [BLK_W-1:0]       key_i,
  output logic [DEPTH-1:0]       hit_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_o[g] = vld_i[g] & ~excl_i[g] & (blk_i[g*BLK_W +: BLK_W] == key_i);
  end
endmodule

// File: rtl/mwb_slot.sv
`timescale 1ns/1ps
module mwb_slot #(
  parameter int BLK_W  = 10,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  localparam int OFS_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_i,
  input  logic                    merge_i,
  input  logic                    clear_i,
  input  logic [BLK_W-1:0]        blk_i,
  input  logic [OFS_W-1:0]        word_i,
  input  logic [DATA_W-1:0]       data_i,
  output logic                    vld_o,
  output logic [BLK_W-1:0]        blk_o,
  output logic [WORDS*DATA_W-1:0] data_o,
  output logic [WORDS-1:0]        mask_o
);
  logic                    vld_d;
  logic [BLK_W-1:0]        blk_d;
  logic [WORDS*DATA_W-1:0] data_d;
  logic [WORDS-1:0]        mask_d;
  logic [WORDS-1:0]        word_oh;

  always_comb begin
    word_oh = '0;
    word_oh[word_i] = 1'b1;
    vld_d  = vld_o;
    blk_d  = blk_o;
    data_d = data_o;
    mask_d = mask_o;
    if (alloc_i) begin
      vld_d  = 1'b1;
      blk_d  = blk_i;
      data_d = '0;
      data_d[word_i*DATA_W +: DATA_W] = data_i;
      mask_d = word_oh;
    end else if (merge_i) begin
      data_d[word_i*DATA_W +: DATA_W] = data_i;
      mask_d = mask_o | word_oh;
    end else if (clear_i) begin
      vld_d  = 1'b0;
      mask_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      blk_o  <= '0;
      data_o <= '0;
      mask_o <= '0;
    end else if (alloc_i | merge_i | clear_i) begin
      vld_o  <= vld_d;
      blk_o  <= blk_d;
      data_o <= data_d;
      mask_o <= mask_d;
    end
  end
endmodule

// File: rtl/merge_write_buffer.sv
`timescale 1ns/1ps
module merge_write_buffer
  import mwb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int DEPTH  = 4,
  localparam int OFS_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int BLK_W = ADDR_W - OFS_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    st_valid,
  output logic                    st_ready,
  input  logic [ADDR_W-1:0]       st_addr,
  input  logic [DATA_W-1:0]       st_data,
  input  logic                    ld_valid,
  input  logic [ADDR_W-1:0]       ld_addr,
  output logic                    ld_hit,
  output logic [DATA_W-1:0]       ld_data,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic [BLK_W-1:0]        mem_blk_addr,
  output logic [WORDS*DATA_W-1:0] mem_data,
  output logic [WORDS-1:0]        mem_mask
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0]        head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic [DEPTH-1:0]        vld, lock, no_excl, st_match, ld_match;
  logic [DEPTH-1:0]        alloc_v, merge_v, clear_v;
  logic [DEPTH*BLK_W-1:0]  blk_flat;
  logic [WORDS*DATA_W-1:0] data_a [DEPTH];
  logic [WORDS-1:0]        mask_a [DEPTH];
  logic [BLK_W-1:0]        st_blk, ld_blk;
  logic [OFS_W-1:0]        st_word, ld_word;
  logic                    merge_hit, full, st_fire, do_alloc, drain;
  fwd_src_e                fwd_src;
  logic [DATA_W-1:0]       fwd_data;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign st_blk  = st_addr[ADDR_W-1:OFS_W];
  assign st_word = st_addr[OFS_W-1:0];
  assign ld_blk  = ld_addr[ADDR_W-1:OFS_W];
  assign ld_word = ld_addr[OFS_W-1:0];
  assign no_excl = '0;

  // the oldest entry is locked while it is offered to memory
  always_comb begin
    lock = '0;
    if (cnt_q != '0) lock[head_q] = 1'b1;
  end

  mwb_cam #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_st_cam (
    .vld_i(vld), .excl_i(lock), .blk_i(blk_flat), .key_i(st_blk), .hit_o(st_match));

  mwb_cam #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_ld_cam (
    .vld_i(vld), .excl_i(no_excl), .blk_i(blk_flat), .key_i(ld_blk), .hit_o(ld_match));

  assign merge_hit = |st_match;
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign st_ready  = merge_hit | ~full;
  assign st_fire   = st_valid & st_ready;
  assign do_alloc  = st_fire & ~merge_hit;
  assign mem_valid = (cnt_q != '0);
  assign drain     = mem_valid & mem_ready;

  always_comb begin
    alloc_v = '0;
    clear_v = '0;
    if (do_alloc) alloc_v[tail_q] = 1'b1;
    if (drain)    clear_v[head_q] = 1'b1;
    merge_v = st_match & {DEPTH{st_fire}};
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    mwb_slot #(.BLK_W(BLK_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .alloc_i(alloc_v[g]), .merge_i(merge_v[g]), .clear_i(clear_v[g]),
      .blk_i(st_blk), .word_i(st_word), .data_i(st_data),
      .vld_o(vld[g]), .blk_o(blk_flat[g*BLK_W +: BLK_W]),
      .data_o(data_a[g]), .mask_o(mask_a[g]));
  end

  // pointer and occupancy next state
  always_comb begin
    head_d = drain    ? ptr_inc(head_q) : head_q;
    tail_d = do_alloc ? ptr_inc(tail_q) : tail_q;
    cnt_d  = cnt_q + CNT_W'(do_alloc) - CNT_W'(drain);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (do_alloc | drain) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign mem_blk_addr = blk_flat[head_q*BLK_W +: BLK_W];
  assign mem_data     = data_a[head_q];
  assign mem_mask     = mask_a[head_q];

  // forwarding: an unlocked copy is always younger than the locked one
  always_comb begin
    fwd_src  = FWD_NONE;
    fwd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ld_match[i] && mask_a[i][ld_word]) begin
        if (!lock[i]) begin
          fwd_src  = FWD_YOUNG;
          fwd_data = data_a[i][ld_word*DATA_W +: DATA_W];
        end else if (fwd_src == FWD_NONE) begin
          fwd_src  = FWD_HEAD;
          fwd_data = data_a[i][ld_word*DATA_W +: DATA_W];
        end
      end
    end
  end

  assign ld_hit  = ld_valid & (fwd_src != FWD_NONE);
  assign ld_data = fwd_data;

  // R2
  merge_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(st_match));
  // R6
  head_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_blk_addr) && $stable(mem_data) && $stable(mem_mask));
  // R3
  alloc_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_alloc && !drain |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  // R7
  drain_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain && !do_alloc |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  // R8
  fwd_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |-> mem_valid);
  // R4
  stall_occupied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> mem_valid);
endmodule

// File: tb/merge_write_buffer_bench.sv
`timescale 1ns/1ps
module merge_write_buffer_bench;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int WORDS  = 4;
  localparam int DEPTH  = 4;
  localparam int OFS_W  = 2;
  localparam int BLK_W  = ADDR_W - OFS_W;

  typedef struct packed {
    logic [BLK_W-1:0]        blk;
    logic [WORDS-1:0]        m;
    logic [WORDS*DATA_W-1:0] d;
  } ent_t;

  logic clk, rst_n;
  logic st_valid, st_ready, ld_valid, ld_hit, mem_valid, mem_ready;
  logic [ADDR_W-1:0] st_addr, ld_addr;
  logic [DATA_W-1:0] st_data, ld_data;
  logic [BLK_W-1:0] mem_blk_addr;
  logic [WORDS*DATA_W-1:0] mem_data;
  logic [WORDS-1:0] mem_mask;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  ent_t q[$];

  merge_write_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .DEPTH(DEPTH))
  u_merge_write_buffer (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ld_hit(ld_hit), .ld_data(ld_data), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_blk_addr(mem_blk_addr), .mem_data(mem_data), .mem_mask(mem_mask));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int find_merge(input logic [BLK_W-1:0] b);
    for (int i = 1; i < q.size(); i++) if (q[i].blk == b) return i;
    return -1;
  endfunction

  // compare all outputs against the model state at the start of the cycle
  task automatic compare();
    bit e_rdy, e_hit;
    logic [DATA_W-1:0] e_ld;
    logic [BLK_W-1:0] lb;
    int lw;
    e_rdy = (find_merge(st_addr[ADDR_W-1:OFS_W]) >= 0) || (q.size() < DEPTH);
    chk(st_ready == e_rdy, "R4", "st_ready", st_ready, e_rdy);
    chk(mem_valid == (q.size() > 0), "R5", "mem_valid", mem_valid, q.size() > 0);
    if (q.size() > 0) begin
      chk(mem_blk_addr == q[0].blk, "R7", "mem_blk_addr", mem_blk_addr, q[0].blk);
      chk(mem_mask == q[0].m, "R5", "mem_mask", mem_mask, q[0].m);
      chk(mem_data == q[0].d, "R5", "mem_data", mem_data, q[0].d);
    end
    e_hit = 1'b0;
    e_ld = '0;
    lb = ld_addr[ADDR_W-1:OFS_W];
    lw = int'(ld_addr[OFS_W-1:0]);
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (!e_hit && q[i].blk == lb && q[i].m[lw]) begin
        e_hit = 1'b1;
        e_ld = q[i].d[lw*DATA_W +: DATA_W];
      end
    end
    e_hit = e_hit && ld_valid;
    chk(ld_hit == e_hit, "R8", "ld_hit", ld_hit, e_hit);
    if (e_hit) chk(ld_data == e_ld, "R8", "ld_data", ld_data, e_ld);
  endtask

  task automatic update();
    bit do_drain;
    int idx, w;
    ent_t e;
    do_drain = (q.size() > 0) && mem_ready;
    if (st_valid) begin
      idx = find_merge(st_addr[ADDR_W-1:OFS_W]);
      w = int'(st_addr[OFS_W-1:0]);
      if (idx >= 0) begin
        e = q[idx];
        e.m[w] = 1'b1;
        e.d[w*DATA_W +: DATA_W] = st_data;
        q[idx] = e;
      end else if (q.size() < DEPTH) begin
        e = '0;
        e.blk = st_addr[ADDR_W-1:OFS_W];
        e.m[w] = 1'b1;
        e.d[w*DATA_W +: DATA_W] = st_data;
        q.push_back(e);
      end
    end
    if (do_drain) void'(q.pop_front());
  endtask

  task automatic step(input bit sv, input int sa, input logic [DATA_W-1:0] sd,
                      input bit lv, input int la, input bit mr);
    @(negedge clk);
    st_valid = sv; st_addr = ADDR_W'(sa); st_data = sd;
    ld_valid = lv; ld_addr = ADDR_W'(la); mem_ready = mr;
    #1 compare();
    @(posedge clk);
    update();
  endtask

  // load probe with an explicit expectation
  task automatic probe(input int la, input bit eh, input logic [DATA_W-1:0] ed, input string tag);
    @(negedge clk);
    st_valid = 0; ld_valid = 1; ld_addr = ADDR_W'(la); mem_ready = 0;
    #1 compare();
    chk(ld_hit == eh, tag, "probe hit", ld_hit, eh);
    if (eh) chk(ld_data == ed, tag, "probe data", ld_data, ed);
    @(posedge clk);
    update();
  endtask

  task automatic peek_head(input int b, input logic [WORDS-1:0] m, input bit v, input string tag);
    #1;
    chk(mem_valid == v, tag, "head valid", mem_valid, v);
    if (v) begin
      chk(mem_blk_addr == BLK_W'(b), tag, "head block", mem_blk_addr, b);
      chk(mem_mask == m, tag, "head mask", mem_mask, m);
    end
  endtask

  initial begin
    rst_n = 0; st_valid = 0; st_addr = '0; st_data = '0;
    ld_valid = 0; ld_addr = '0; mem_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1
    @(negedge clk);
    ld_valid = 1; ld_addr = '0; #1;
    chk(mem_valid == 0, "R1", "mem_valid", mem_valid, 0);
    chk(st_ready == 1, "R1", "st_ready", st_ready, 1);
    chk(ld_hit == 0, "R1", "ld_hit", ld_hit, 0);

    // consecutive words of block 5, memory stalled
    for (int w = 0; w < 4; w++) step(1, 5*4 + w, 32'hA0 + w, 0, 0, 0);
    peek_head(5, 4'b0001, 1, "R6");
    probe(5*4 + 1, 1, 32'hA1, "R2");
    probe(5*4 + 0, 1, 32'hA0, "R8");
    step(1, 5*4 + 0, 32'hB0, 0, 0, 0);   // locked head: merges into younger copy
    probe(5*4 + 0, 1, 32'hB0, "R8");
    peek_head(5, 4'b0001, 1, "R6");
    // fill to full
    step(1, 7*4 + 2, 32'hC2, 0, 0, 0);
    step(1, 9*4 + 3, 32'hD3, 0, 0, 0);
    @(negedge clk);
    st_valid = 1; st_addr = ADDR_W'(11*4); st_data = 32'hEE; ld_valid = 0; mem_ready = 0;
    #1 chk(st_ready == 0, "R4", "full stall", st_ready, 0);
    compare();
    @(posedge clk); update();
    step(1, 7*4 + 0, 32'hC0, 0, 0, 0);   // merge while full
    probe(11*4, 0, 0, "R9");
    probe(9*4 + 0, 0, 0, "R8");
    probe(7*4 + 0, 1, 32'hC0, "R2");
    // drain in order
    step(0, 0, 0, 0, 0, 1);
    peek_head(5, 4'b1111, 1, "R7");
    chk(mem_data == {32'hA3, 32'hA2, 32'hA1, 32'hB0}, "R2", "merged data", mem_data,
        {32'hA3, 32'hA2, 32'hA1, 32'hB0});
    step(0, 0, 0, 0, 0, 1);
    peek_head(7, 4'b0101, 1, "R7");
    chk(mem_data == {32'h0, 32'hC2, 32'h0, 32'hC0}, "R3", "zero fill", mem_data,
        {32'h0, 32'hC2, 32'h0, 32'hC0});
    step(0, 0, 0, 0, 0, 1);
    peek_head(9, 4'b1000, 1, "R7");
    step(0, 0, 0, 0, 0, 1);
    peek_head(0, 4'b0000, 0, "R7");
    // allocate while draining
    step(1, 1*4, 32'h11, 0, 0, 0);
    step(1, 2*4, 32'h22, 0, 0, 0);
    step(1, 3*4, 32'h33, 0, 0, 1);
    peek_head(2, 4'b0001, 1, "R10");
    step(0, 0, 0, 0, 0, 1);
    peek_head(3, 4'b0001, 1, "R10");
    step(0, 0, 0, 0, 0, 1);
    peek_head(0, 4'b0000, 0, "R10");

    // random mix over a few blocks
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 10) < 6, int'($urandom % 24), $urandom,
           ($urandom % 2) == 1, int'($urandom % 24), ($urandom % 10) < 3);
    end
    repeat (8) step(0, 0, 0, 0, 0, 1);
    summary();
    $finish;
  end
endmodule